// File: doc/BRIEF.md
# Slotted Command-Stream Receive Buffer

This block takes a single word stream in which each word is tagged with a two-bit type. The tag tells packet framing and control words apart from packet payload words. The block strips the framing and writes each packet into one slot of an internal store. A slot is a fixed number of words. Control words fill the slot from word 0 upward. Payload words fill it from a parameterized word offset upward. When the closing word of a packet arrives, the block records the payload length in bytes in a per-slot status register and marks the slot occupied. It then raises a level interrupt towards software.

Slots are taken in circular order. Software reads any word of any slot, and its status length, through a registered read port. It hands a slot back by acknowledging it. If the next slot in turn is still occupied when a new packet would start, the input is stalled until software frees that slot.

Top module: `cmd_slot_buffer`

## Requirements
- R1: After reset, `in_ready` is 1, `irq` is 0 and `slot_full` is all zeros.
- R2: Type 2'b10 opens a packet and is stored at word 0 of the current slot. Each following type 2'b00 word is stored at the next word (1, 2, …) while the index is below `DATA_OFS`. Any further control words are dropped.
- R3: Type 2'b01 words, and the type 2'b11 word that closes the packet, are stored from word `DATA_OFS` upward in arrival order. Words that would go past the last word of the slot are dropped.
- R4: Accepting the type 2'b11 word sets the slot's bit in `slot_full`. It also records the stored payload length in the slot's status register: stored payload words times `W/8` bytes.
- R5: `irq` is high in exactly those cycles in which at least one `slot_full` bit is set.
- R6: A cycle with `ack_valid` high clears `slot_full[ack_slot]`. Acknowledging a slot that is not full changes nothing.
- R7: Successive packets go to slots 0, 1, …, `NSLOTS-1`, then wrap to 0.
- R8: While no packet is open and the next slot is full, `in_ready` is 0 and no word is taken.
- R9: Words of type 2'b00, 2'b01 or 2'b11 that arrive while no packet is open are discarded. They leave all slot state and the slot order unchanged.
- R10: A type 2'b10 word that arrives inside an open packet restarts that packet in the same slot, with the control and payload positions reset.
- R11: `rd_data` and `rd_len` show the word and status selected by `rd_slot`/`rd_word` one clock after the selection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word present |
| in_type | input | 2 | Word type: 00 control, 01 payload, 10 packet open, 11 packet close |
| in_data | input | W | Input word |
| in_ready | output | 1 | Block accepts the word this cycle |
| rd_slot | input | clog2(NSLOTS) | Slot selected for reading |
| rd_word | input | clog2(SLOT_WORDS) | Word within the slot selected for reading |
| rd_data | output | W | Selected word, one cycle later |
| rd_len | output | 16 | Payload byte length of the selected slot, one cycle later |
| ack_valid | input | 1 | Release request |
| ack_slot | input | clog2(NSLOTS) | Slot to release |
| slot_full | output | NSLOTS | Per-slot occupied flags |
| irq | output | 1 | Level interrupt: some slot occupied |

## Verification
A word is taken at the rising edge where `in_valid` and `in_ready` are both high. The memory write, the `slot_full` bit and `irq` all follow that same edge, so the bench drives on falling edges and checks flags at the next falling edge. Read results are one register deep. The bench sets the address on one falling edge and samples `rd_data`/`rd_len` on the next. An acknowledge clears its flag at the following edge and is checked one half-cycle later, as is the stall state of `in_ready`, which depends only on registered state.

// File: rtl/obuf_pkg.sv
package obuf_pkg;

  typedef enum logic [1:0] {
    WT_CTRL = 2'b00,
    WT_DATA = 2'b01,
    WT_OPEN = 2'b10,
    WT_CLOSE = 2'b11
  } wtype_e;

  // Linear word index of (slot, word) in the flat store.
  function automatic int unsigned flat_index(input int unsigned slot,
                                             input int unsigned word,
                                             input int unsigned slot_words);
    return slot * slot_words + word;
  endfunction

  // Byte count held by a number of payload words.
  function automatic int unsigned bytes_of(input int unsigned words,
                                           input int unsigned word_bits);
    return words * (word_bits / 8);
  endfunction

endpackage

// File: rtl/stream_parser.sv
module stream_parser
  import obuf_pkg::*;
#(
  parameter int W          = 32,
  parameter int SLOT_WORDS = 16,
  parameter int DATA_OFS   = 4,
  parameter int LEN_W      = 16,
  localparam int IW        = $clog2(SLOT_WORDS),
  localparam int CW        = $clog2(SLOT_WORDS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc,
  input  logic [1:0]       in_type,
  output logic             wr_en,
  output logic [IW-1:0]    wr_word,
  output logic             in_pkt,
  output logic             ev_sop,
  output logic             ev_eop,
  output logic [LEN_W-1:0] eop_len
);

  localparam logic [CW-1:0] OFS_C   = CW'(DATA_OFS);
  localparam logic [CW-1:0] WORDS_C = CW'(SLOT_WORDS);

  logic [CW-1:0] cidx;
  logic [CW-1:0] didx;
  logic          ctrl_ok;
  logic          data_ok;
  wtype_e        wt;

  assign wt      = wtype_e'(in_type);
  assign ctrl_ok = cidx < OFS_C;
  assign data_ok = (OFS_C + didx) < WORDS_C;
  assign ev_sop  = acc && (wt == WT_OPEN);
  assign ev_eop  = acc && in_pkt && (wt == WT_CLOSE);
  assign eop_len = LEN_W'(bytes_of(32'(didx) + (data_ok ? 1 : 0), W));

  always_comb begin
    wr_en   = 1'b0;
    wr_word = '0;
    unique case (wt)
      WT_OPEN: begin
        wr_en   = acc;
        wr_word = '0;
      end
      WT_CTRL: begin
        wr_en   = acc && in_pkt && ctrl_ok;
        wr_word = IW'(cidx);
      end
      WT_DATA, WT_CLOSE: begin
        wr_en   = acc && in_pkt && data_ok;
        wr_word = IW'(OFS_C + didx);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_pkt <= 1'b0;
      cidx   <= '0;
      didx   <= '0;
    end else if (ev_sop) begin
      in_pkt <= 1'b1;
      cidx   <= CW'(1);
      didx   <= '0;
    end else if (acc && in_pkt) begin
      if (wt == WT_CTRL && ctrl_ok) cidx <= cidx + CW'(1);
      if ((wt == WT_DATA || wt == WT_CLOSE) && data_ok) didx <= didx + CW'(1);
      if (wt == WT_CLOSE) in_pkt <= 1'b0;
    end
  end

endmodule

// File: rtl/slot_tracker.sv
module slot_tracker #(
  parameter int NSLOTS = 4,
  localparam int SW    = $clog2(NSLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_eop,
  input  logic              ack_valid,
  input  logic [SW-1:0]     ack_slot,
  output logic [SW-1:0]     wr_ptr,
  output logic [NSLOTS-1:0] slot_full,
  output logic              ev_ack
);

  localparam logic [SW-1:0] LAST_C = SW'(NSLOTS - 1);

  assign ev_ack = ack_valid && slot_full[ack_slot];

  always_ff @(posedge clk) begin
    if (!rst_n)       wr_ptr <= '0;
    else if (ev_eop)  wr_ptr <= (wr_ptr == LAST_C) ? '0 : wr_ptr + SW'(1);
  end

  for (genvar g = 0; g < NSLOTS; g++) begin : g_flag
    logic set_g;
    logic clr_g;
    assign set_g = ev_eop && (wr_ptr == SW'(g));
    assign clr_g = ack_valid && (ack_slot == SW'(g));
    always_ff @(posedge clk) begin
      if (!rst_n)     slot_full[g] <= 1'b0;
      else if (set_g) slot_full[g] <= 1'b1;
      else if (clr_g) slot_full[g] <= 1'b0;
    end
  end

endmodule

// File: rtl/slot_store.sv
module slot_store
  import obuf_pkg::*;
#(
  parameter int W          = 32,
  parameter int NSLOTS     = 4,
  parameter int SLOT_WORDS = 16,
  parameter int LEN_W      = 16,
  localparam int SW        = $clog2(NSLOTS),
  localparam int IW        = $clog2(SLOT_WORDS),
  localparam int DEPTH     = NSLOTS * SLOT_WORDS,
  localparam int AW        = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SW-1:0]    wr_slot,
  input  logic [IW-1:0]    wr_word,
  input  logic [W-1:0]     wr_data,
  input  logic             len_we,
  input  logic [LEN_W-1:0] len_in,
  input  logic [SW-1:0]    rd_slot,
  input  logic [IW-1:0]    rd_word,
  output logic [W-1:0]     rd_data,
  output logic [LEN_W-1:0] rd_len
);

  logic [W-1:0]     mem  [DEPTH];
  logic [LEN_W-1:0] lens [NSLOTS];
  logic [AW-1:0]    wa;
  logic [AW-1:0]    ra;

  assign wa = AW'(flat_index(32'(wr_slot), 32'(wr_word), SLOT_WORDS));
  assign ra = AW'(flat_index(32'(rd_slot), 32'(rd_word), SLOT_WORDS));

  always_ff @(posedge clk) begin
    if (wr_en) mem[wa] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NSLOTS; i++) lens[i] <= '0;
    end else if (len_we) begin
      lens[wr_slot] <= len_in;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data <= '0;
      rd_len  <= '0;
    end else begin
      rd_data <= mem[ra];
      rd_len  <= lens[rd_slot];
    end
  end

endmodule

// File: rtl/cmd_slot_buffer.sv
module cmd_slot_buffer #(
  parameter int W          = 32,
  parameter int NSLOTS     = 4,
  parameter int SLOT_WORDS = 16,
  parameter int DATA_OFS   = 4,
  localparam int SW        = $clog2(NSLOTS),
  localparam int IW        = $clog2(SLOT_WORDS),
  localparam int LEN_W     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [1:0]        in_type,
  input  logic [W-1:0]      in_data,
  output logic              in_ready,
  input  logic [SW-1:0]     rd_slot,
  input  logic [IW-1:0]     rd_word,
  output logic [W-1:0]      rd_data,
  output logic [LEN_W-1:0]  rd_len,
  input  logic              ack_valid,
  input  logic [SW-1:0]     ack_slot,
  output logic [NSLOTS-1:0] slot_full,
  output logic              irq
);

  logic             acc;
  logic             ev_wr;
  logic [IW-1:0]    wr_word;
  logic             in_pkt;
  logic             ev_sop;
  logic             ev_eop;
  logic             ev_ack;
  logic [LEN_W-1:0] eop_len;
  logic [SW-1:0]    wr_ptr;

  assign in_ready = in_pkt || !slot_full[wr_ptr];
  assign acc      = in_valid && in_ready;
  assign irq      = |slot_full;

  stream_parser #(
    .W(W), .SLOT_WORDS(SLOT_WORDS), .DATA_OFS(DATA_OFS), .LEN_W(LEN_W)
  ) u_parse (
    .clk(clk), .rst_n(rst_n), .acc(acc), .in_type(in_type),
    .wr_en(ev_wr), .wr_word(wr_word), .in_pkt(in_pkt),
    .ev_sop(ev_sop), .ev_eop(ev_eop), .eop_len(eop_len)
  );

  slot_tracker #(.NSLOTS(NSLOTS)) u_track (
    .clk(clk), .rst_n(rst_n), .ev_eop(ev_eop),
    .ack_valid(ack_valid), .ack_slot(ack_slot),
    .wr_ptr(wr_ptr), .slot_full(slot_full), .ev_ack(ev_ack)
  );

  slot_store #(
    .W(W), .NSLOTS(NSLOTS), .SLOT_WORDS(SLOT_WORDS), .LEN_W(LEN_W)
  ) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(ev_wr), .wr_slot(wr_ptr), .wr_word(wr_word), .wr_data(in_data),
    .len_we(ev_eop), .len_in(eop_len),
    .rd_slot(rd_slot), .rd_word(rd_word), .rd_data(rd_data), .rd_len(rd_len)
  );

endmodule

// File: rtl/obuf_checker.sv
module obuf_checker #(
  parameter int W          = 32,
  parameter int NSLOTS     = 4,
  parameter int SLOT_WORDS = 16,
  parameter int DATA_OFS   = 4,
  localparam int SW        = $clog2(NSLOTS),
  localparam int LEN_W     = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              ack_valid,
  input logic [SW-1:0]     ack_slot,
  input logic [NSLOTS-1:0] slot_full,
  input logic              irq,
  input logic              in_pkt,
  input logic [SW-1:0]     wr_ptr,
  input logic              ev_sop,
  input logic              ev_eop,
  input logic              ev_ack,
  input logic [LEN_W-1:0]  eop_len
);

  localparam int MAXB = (SLOT_WORDS - DATA_OFS) * (W / 8);

  p_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_ready && !ack_valid) |=> $stable(slot_full));

  p_irq_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(ev_eop));

  p_full_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_eop |=> slot_full[$past(wr_ptr)]);

  p_new_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((slot_full & ~$past(slot_full)) != '0) |-> $past(ev_eop));

  p_ack_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ack |=> !slot_full[$past(ack_slot)]);

  p_len_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_eop |-> (32'(eop_len) <= MAXB && 32'(eop_len) >= (W / 8)));

  p_ptr_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_eop |=> (wr_ptr == (($past(wr_ptr) == SW'(NSLOTS - 1)) ? '0 : $past(wr_ptr) + SW'(1))));

  p_open_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_sop |=> in_pkt);

  p_irq_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !ack_valid) |=> irq);

endmodule

bind cmd_slot_buffer obuf_checker #(
  .W(W), .NSLOTS(NSLOTS), .SLOT_WORDS(SLOT_WORDS), .DATA_OFS(DATA_OFS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .ack_valid(ack_valid), .ack_slot(ack_slot), .slot_full(slot_full),
  .irq(irq), .in_pkt(in_pkt), .wr_ptr(wr_ptr), .ev_sop(ev_sop),
  .ev_eop(ev_eop), .ev_ack(ev_ack), .eop_len(eop_len)
);

// File: tb/tb_cmd_slot_buffer.sv
module tb_cmd_slot_buffer;

  localparam int W = 32, NSLOTS = 4, SLOT_WORDS = 16, DATA_OFS = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [1:0]  in_type = 2'b00;
  logic [31:0] in_data = '0;
  logic        in_ready;
  logic [1:0]  rd_slot = '0;
  logic [3:0]  rd_word = '0;
  logic [31:0] rd_data;
  logic [15:0] rd_len;
  logic        ack_valid = 1'b0;
  logic [1:0]  ack_slot = '0;
  logic [3:0]  slot_full;
  logic        irq;

  int nchk = 0;
  int nbad = 0;

  always #5 clk = ~clk;

  cmd_slot_buffer #(.W(W), .NSLOTS(NSLOTS), .SLOT_WORDS(SLOT_WORDS), .DATA_OFS(DATA_OFS)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_type(in_type), .in_data(in_data),
    .in_ready(in_ready), .rd_slot(rd_slot), .rd_word(rd_word), .rd_data(rd_data),
    .rd_len(rd_len), .ack_valid(ack_valid), .ack_slot(ack_slot),
    .slot_full(slot_full), .irq(irq)
  );

  function automatic logic [31:0] cw(input int p, input int i);
    return 32'hC000_0000 | (p << 8) | i;
  endfunction
  function automatic logic [31:0] dw(input int p, input int j);
    return 32'hD000_0000 | (p << 8) | j;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic put(input logic [1:0] t, input logic [31:0] d);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; in_type = t; in_data = d;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic send_pkt(input int p, input int nctrl, input int ndata);
    put(2'b10, cw(p, 0));
    for (int i = 1; i < nctrl; i++) put(2'b00, cw(p, i));
    for (int j = 0; j < ndata - 1; j++) put(2'b01, dw(p, j));
    put(2'b11, dw(p, ndata - 1));
  endtask

  task automatic rd(input int s, input int wd, output logic [31:0] d, output logic [15:0] l);
    @(negedge clk);
    rd_slot = 2'(s); rd_word = 4'(wd);
    @(negedge clk);
    d = rd_data; l = rd_len;
  endtask

  task automatic ack(input int s);
    @(negedge clk);
    ack_valid = 1'b1; ack_slot = 2'(s);
    @(negedge clk);
    ack_valid = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 in_ready", 32'(in_ready), 1);
    check("R1 irq", 32'(irq), 0);
    check("R1 slot_full", 32'(slot_full), 0);
  endtask

  task automatic t_basic;
    logic [31:0] d; logic [15:0] l;
    send_pkt(1, 2, 3);
    check("R4 slot0 full", 32'(slot_full), 32'b0001);
    check("R5 irq", 32'(irq), 1);
    rd(0, 0, d, l); check("R2 word0 open", d, cw(1, 0));
    check("R4 len", 32'(l), 12);
    rd(0, 1, d, l); check("R2 word1 ctrl", d, cw(1, 1));
    rd(0, 4, d, l); check("R3 word4 data", d, dw(1, 0));
    rd(0, 6, d, l); check("R3 word6 close", d, dw(1, 2));
    @(negedge clk); rd_slot = 2'd0; rd_word = 4'd1;
    @(posedge clk); #1 rd_word = 4'd4;
    @(negedge clk); check("R11 one-cycle latency", rd_data, cw(1, 1));
  endtask

  task automatic t_ctrl_overflow;
    logic [31:0] d; logic [15:0] l;
    send_pkt(2, 6, 1);
    check("R7 slot1 full", 32'(slot_full), 32'b0011);
    rd(1, 3, d, l); check("R2 last ctrl slot", d, cw(2, 3));
    rd(1, 4, d, l); check("R2 extra ctrl dropped", d, dw(2, 0));
    check("R4 len one word", 32'(l), 4);
  endtask

  task automatic t_data_overflow;
    logic [31:0] d; logic [15:0] l;
    send_pkt(3, 1, 14);
    rd(2, 15, d, l); check("R3 last slot word", d, dw(3, 11));
    check("R3 len capped", 32'(l), 48);
    rd(2, 4, d, l); check("R3 first data", d, dw(3, 0));
  endtask

  task automatic t_stall;
    send_pkt(4, 1, 1);
    check("R7 all full", 32'(slot_full), 32'b1111);
    check("R8 not ready", 32'(in_ready), 0);
    @(negedge clk); in_valid = 1'b1; in_type = 2'b10; in_data = cw(9, 0);
    repeat (3) @(negedge clk);
    check("R8 still stalled", 32'(in_ready), 0);
    check("R8 flags unchanged", 32'(slot_full), 32'b1111);
    in_valid = 1'b0;
  endtask

  task automatic t_ack_wrap;
    logic [31:0] d; logic [15:0] l;
    ack(0);
    check("R6 slot0 freed", 32'(slot_full), 32'b1110);
    check("R5 irq stays", 32'(irq), 1);
    check("R8 ready again", 32'(in_ready), 1);
    ack(0);
    check("R6 ack of empty slot", 32'(slot_full), 32'b1110);
    send_pkt(5, 1, 2);
    check("R7 wrap to slot0", 32'(slot_full), 32'b1111);
    rd(0, 0, d, l); check("R7 slot0 reused", d, cw(5, 0));
    for (int s = 0; s < 4; s++) ack(s);
    check("R6 all freed", 32'(slot_full), 0);
    check("R5 irq low", 32'(irq), 0);
  endtask

  task automatic t_stray;
    put(2'b00, 32'h1111_1111);
    put(2'b01, 32'h2222_2222);
    put(2'b11, 32'h3333_3333);
    check("R9 no slot filled", 32'(slot_full), 0);
    check("R9 irq low", 32'(irq), 0);
  endtask

  task automatic t_restart;
    logic [31:0] d; logic [15:0] l;
    put(2'b10, cw(7, 0));
    put(2'b00, cw(7, 1));
    put(2'b01, dw(7, 0));
    put(2'b10, cw(8, 0));
    put(2'b01, dw(8, 0));
    put(2'b11, dw(8, 1));
    check("R9 order kept, R10 slot1", 32'(slot_full), 32'b0010);
    rd(1, 0, d, l); check("R10 new open word", d, cw(8, 0));
    check("R10 len restarted", 32'(l), 8);
    rd(1, 4, d, l); check("R10 data restarted", d, dw(8, 0));
    rd(1, 5, d, l); check("R10 close word", d, dw(8, 1));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_ctrl_overflow();
    t_data_overflow();
    t_stall();
    t_ack_wrap();
    t_stray();
    t_restart();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end

endmodule